// File: doc/BRIEF.md
# Remote Control Pulse Pattern Receiver

This block decodes infrared-style remote control frames from a digital input that has already been synchronized to the clock. A counter advances on each cycle in which a count-source enable is high. On selected edges of the input the counter value is taken as an interval measurement and the counter restarts. Each measurement is sorted against three programmable min/max windows: one for the header, one for a data-0 symbol and one for a data-1 symbol. A header-sized interval that arrives after the header has already been seen is a special pattern.

Data symbols are shifted into a 48-bit receive buffer, and a bit count tracks how many have arrived. The match flags always show the class of the latest accepted measurement. An error flag records an interval that fits no window. A frame ends by itself when the line stays quiet longer than the largest programmed maximum.

Top module: `ir_frame_rx`

## Requirements
- R1: With `meas_mode` = 00 (and also 11), a rising input edge starts a frame while idle. During a frame, each rising edge measures the interval since the previous rising edge and restarts the counter. Falling edges have no effect.
- R2: With `meas_mode` = 01, a rising edge starts a frame while idle and restarts the counter during a frame without measuring. Each falling edge during a frame measures the high time. A falling edge while idle does not start a frame.
- R3: With `meas_mode` = 10, either edge starts a frame while idle. During a frame, every edge measures the interval since the previous edge and restarts the counter.
- R4: An input change is detected at the first clock edge after it appears. The measured value is the number of clock cycles with `cnt_tick` high strictly between the cycle that detects the restarting edge and the cycle that detects the measuring edge. `rx_busy` stays 1 for the whole frame. It falls at the first `cnt_tick` cycle in which the counter already exceeds the largest of the three maxima. While `cnt_tick` is low the counter holds, so the frame does not end.
- R5: While `enable` is 0, every output flag, `bit_cnt` and `rx_buf` are held at 0.
- R6: The first measurement in a frame that lies inside the header window (min and max inclusive) sets `hdr_hit` and clears the other match flags.
- R7: A later header-window measurement in the same frame sets `spc_hit` and clears the other match flags.
- R8: A data-0 window match sets `d0_hit` and shifts a 0 into bit 0 of `rx_buf`. A data-1 window match sets `d1_hit` and shifts a 1. Older bits move one place toward the MSB. When windows overlap, header wins over data-0, and data-0 wins over data-1. At most one match flag is ever set.
- R9: A measurement during a frame that lies in no window sets `err_flag` and clears all match flags. `err_flag` stays set until the next frame start or until the block is disabled.
- R10: With `hdr_en` = 1, data-0, data-1 and special matches change no flag, buffer or count until a header has been matched in the current frame.
- R11: A frame start clears all match flags, `err_flag`, `buf_full`, `bit_cnt` and `rx_buf`.
- R12: Each data bit increments `bit_cnt`. `buf_full` sets when the count steps from 47 to 48. The next bit wraps the count to 1 and clears `buf_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Receiver enable; 0 clears all state |
| cnt_tick | input | 1 | Count-source enable for the interval counter |
| sig_in | input | 1 | Synchronized remote control input |
| meas_mode | input | 2 | 00 period, 01 high width, 10 every-edge width |
| hdr_en | input | 1 | Require a header before data is accepted |
| hdr_min | input | CW | Header window lower bound |
| hdr_max | input | CW | Header window upper bound |
| d0_min | input | CW | Data-0 window lower bound |
| d0_max | input | CW | Data-0 window upper bound |
| d1_min | input | CW | Data-1 window lower bound |
| d1_max | input | CW | Data-1 window upper bound |
| rx_busy | output | 1 | Frame in progress |
| buf_full | output | 1 | 48 bits received |
| hdr_hit | output | 1 | Latest class: header |
| d0_hit | output | 1 | Latest class: data-0 |
| d1_hit | output | 1 | Latest class: data-1 |
| spc_hit | output | 1 | Latest class: special (repeat header) |
| err_flag | output | 1 | Out-of-window measurement seen |
| bit_cnt | output | 6 | Received bit count |
| rx_buf | output | 48 | Receive shift register, newest bit at bit 0 |

## Verification
The assertions assume the window and mode inputs stay constant during a frame and that `sig_in` is already free of metastability. The stimulus changes `meas_mode`, `hdr_en` and the windows only while `rx_busy` is low or the block is disabled. It changes `sig_in` only on falling clock edges, so every edge is detected at one known rising clock edge. All interval lengths are whole clock counts, chosen to land well inside, or clearly outside, the programmed windows.

// File: rtl/irrx_pkg.sv
// Shared definitions for the remote control pulse pattern receiver.
// Assumes nothing beyond the standard two-valued encodings below.
package irrx_pkg;

    // Edge selection for interval measurement (11 behaves as 00).
    typedef enum logic [1:0] {
        MODE_PERIOD = 2'b00,
        MODE_HIGH   = 2'b01,
        MODE_WIDTH  = 2'b10,
        MODE_SPARE  = 2'b11
    } irrx_mode_e;

    // Window bank layout: index order is also match priority.
    localparam int NUM_WIN = 3;
    localparam int WIN_HDR = 0;
    localparam int WIN_D0  = 1;
    localparam int WIN_D1  = 2;

endpackage

// File: rtl/irrx_edge_timer.sv
// Edge detector and interval counter.
// Finds input edges, decides which edges start a frame, restart the counter
// or measure, and flags the quiet-line timeout. Assumes sig_in is synchronous.
module irrx_edge_timer
    import irrx_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cnt_tick,
    input  logic          sig_in,
    input  irrx_mode_e    mode,
    input  logic          busy,
    input  logic [CW-1:0] limit,
    output logic          start_ev,
    output logic          meas_ev,
    output logic          timeout_ev,
    output logic [CW-1:0] meas_val
);

    localparam logic [CW-1:0] CNT_TOP = '1;

    logic          sig_q;
    logic [CW-1:0] cnt_q;
    logic          rise, fall, restart_edge, meas_edge;

    // Remember the input level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    // Decode edges per mode: which edge restarts and which one measures.
    always_comb begin
        rise = sig_in & ~sig_q;
        fall = ~sig_in & sig_q;
        unique case (mode)
            MODE_HIGH: begin
                restart_edge = rise;
                meas_edge    = fall;
            end
            MODE_WIDTH: begin
                restart_edge = rise | fall;
                meas_edge    = rise | fall;
            end
            default: begin
                restart_edge = rise;
                meas_edge    = rise;
            end
        endcase
    end

    // Saturating interval counter, restarted by the restarting edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)  cnt_q <= '0;
        else if (restart_edge)  cnt_q <= '0;
        else if (cnt_tick && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign start_ev   = enable & ~busy & restart_edge;
    assign meas_ev    = enable & busy & meas_edge;
    assign timeout_ev = enable & busy & cnt_tick & ~restart_edge & (cnt_q > limit);
    assign meas_val   = cnt_q;

endmodule

// File: rtl/irrx_window_bank.sv
// Window comparator bank.
// Checks one measurement against NW inclusive min/max windows and gives the
// largest maximum as the timeout limit. Purely combinational.
module irrx_window_bank #(
    parameter int CW = 16,
    parameter int NW = 3
) (
    input  logic [CW-1:0]         val,
    input  logic [NW-1:0][CW-1:0] wmin,
    input  logic [NW-1:0][CW-1:0] wmax,
    output logic [NW-1:0]         hit,
    output logic [CW-1:0]         limit
);

    // One inclusive range compare per window.
    for (genvar g = 0; g < NW; g++) begin : g_win
        assign hit[g] = (val >= wmin[g]) && (val <= wmax[g]);
    end

    // Largest maximum across all windows.
    always_comb begin
        limit = '0;
        for (int i = 0; i < NW; i++) begin
            if (wmax[i] > limit) limit = wmax[i];
        end
    end

endmodule

// File: rtl/irrx_frame_ctrl.sv
// Frame state, match flags, bit counter and receive shift register.
// Assumes start_ev only arrives while idle and meas_ev only while busy.
module irrx_frame_ctrl
    import irrx_pkg::*;
#(
    parameter int BUF_W = 48,
    parameter int BCW   = $clog2(BUF_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               hdr_en,
    input  logic               start_ev,
    input  logic               meas_ev,
    input  logic               timeout_ev,
    input  logic [NUM_WIN-1:0] hit,
    output logic               busy,
    output logic               full,
    output logic               hdr_hit,
    output logic               d0_hit,
    output logic               d1_hit,
    output logic               spc_hit,
    output logic               err,
    output logic [BCW-1:0]     bit_cnt,
    output logic [BUF_W-1:0]   rx_buf
);

    localparam logic [BCW-1:0] CNT_LAST = BCW'(BUF_W);
    localparam logic [BCW-1:0] CNT_PRE  = BCW'(BUF_W - 1);

    logic hdr_seen;
    logic gate_open;

    assign gate_open = ~hdr_en | hdr_seen;

    // Frame sequencing, classification result and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || start_ev) begin
            busy     <= start_ev && rst_n && enable;
            full     <= 1'b0;
            hdr_hit  <= 1'b0;
            d0_hit   <= 1'b0;
            d1_hit   <= 1'b0;
            spc_hit  <= 1'b0;
            err      <= 1'b0;
            hdr_seen <= 1'b0;
            bit_cnt  <= '0;
            rx_buf   <= '0;
        end else begin
            if (timeout_ev) busy <= 1'b0;
            if (meas_ev) begin
                if (hit[WIN_HDR]) begin
                    if (!hdr_seen) begin
                        {hdr_hit, d0_hit, d1_hit, spc_hit} <= 4'b1000;
                        hdr_seen <= 1'b1;
                    end else begin
                        {hdr_hit, d0_hit, d1_hit, spc_hit} <= 4'b0001;
                    end
                end else if (hit[WIN_D0] || hit[WIN_D1]) begin
                    if (gate_open) begin
                        d0_hit  <= hit[WIN_D0];
                        d1_hit  <= ~hit[WIN_D0];
                        hdr_hit <= 1'b0;
                        spc_hit <= 1'b0;
                        rx_buf  <= {rx_buf[BUF_W-2:0], ~hit[WIN_D0]};
                        if (bit_cnt == CNT_LAST) begin
                            bit_cnt <= BCW'(1);
                            full    <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == CNT_PRE) full <= 1'b1;
                        end
                    end
                end else begin
                    {hdr_hit, d0_hit, d1_hit, spc_hit} <= 4'b0000;
                    err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ir_frame_rx.sv
// Top of the remote control pulse pattern receiver.
// Ties the edge timer, the window bank and the frame controller together.
// Assumes sig_in is synchronized and windows are stable during a frame.
module ir_frame_rx
    import irrx_pkg::*;
#(
    parameter  int CW    = 16,
    parameter  int BUF_W = 48,
    localparam int BCW   = $clog2(BUF_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cnt_tick,
    input  logic             sig_in,
    input  logic [1:0]       meas_mode,
    input  logic             hdr_en,
    input  logic [CW-1:0]    hdr_min,
    input  logic [CW-1:0]    hdr_max,
    input  logic [CW-1:0]    d0_min,
    input  logic [CW-1:0]    d0_max,
    input  logic [CW-1:0]    d1_min,
    input  logic [CW-1:0]    d1_max,
    output logic             rx_busy,
    output logic             buf_full,
    output logic             hdr_hit,
    output logic             d0_hit,
    output logic             d1_hit,
    output logic             spc_hit,
    output logic             err_flag,
    output logic [BCW-1:0]   bit_cnt,
    output logic [BUF_W-1:0] rx_buf
);

    logic [NUM_WIN-1:0][CW-1:0] wmin, wmax;
    logic [NUM_WIN-1:0]         hit;
    logic [CW-1:0]              limit, meas_val;
    logic                       start_ev, meas_ev, timeout_ev;

    // Pack the window inputs in priority order.
    always_comb begin
        wmin[WIN_HDR] = hdr_min;
        wmax[WIN_HDR] = hdr_max;
        wmin[WIN_D0]  = d0_min;
        wmax[WIN_D0]  = d0_max;
        wmin[WIN_D1]  = d1_min;
        wmax[WIN_D1]  = d1_max;
    end

    irrx_edge_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cnt_tick   (cnt_tick),
        .sig_in     (sig_in),
        .mode       (irrx_mode_e'(meas_mode)),
        .busy       (rx_busy),
        .limit      (limit),
        .start_ev   (start_ev),
        .meas_ev    (meas_ev),
        .timeout_ev (timeout_ev),
        .meas_val   (meas_val)
    );

    irrx_window_bank #(.CW(CW), .NW(NUM_WIN)) u_bank (
        .val   (meas_val),
        .wmin  (wmin),
        .wmax  (wmax),
        .hit   (hit),
        .limit (limit)
    );

    irrx_frame_ctrl #(.BUF_W(BUF_W), .BCW(BCW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .hdr_en     (hdr_en),
        .start_ev   (start_ev),
        .meas_ev    (meas_ev),
        .timeout_ev (timeout_ev),
        .hit        (hit),
        .busy       (rx_busy),
        .full       (buf_full),
        .hdr_hit    (hdr_hit),
        .d0_hit     (d0_hit),
        .d1_hit     (d1_hit),
        .spc_hit    (spc_hit),
        .err        (err_flag),
        .bit_cnt    (bit_cnt),
        .rx_buf     (rx_buf)
    );

endmodule

// File: rtl/irrx_checker.sv
// Property checker for ir_frame_rx, attached through bind.
// Watches only top-level ports; assumes synchronous active-low reset.
module irrx_checker #(
    parameter  int BUF_W = 48,
    localparam int BCW   = $clog2(BUF_W + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           rx_busy,
    input logic           buf_full,
    input logic           hdr_hit,
    input logic           d0_hit,
    input logic           d1_hit,
    input logic           spc_hit,
    input logic           err_flag,
    input logic [BCW-1:0] bit_cnt
);

    logic [3:0] flags;
    assign flags = {hdr_hit, d0_hit, d1_hit, spc_hit};

    assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rx_busy && !buf_full && !err_flag && flags == 4'b0 && bit_cnt == '0));

    assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> (bit_cnt == '0 && !buf_full && !err_flag && flags == 4'b0));

    assert_err_clears_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> flags == 4'b0);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> (!$past(enable) || $rose(rx_busy)));

    assert_full_at_top_R12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> bit_cnt == BCW'(BUF_W));

    assert_full_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> $past(bit_cnt) == BCW'(BUF_W - 1));

    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BCW'(BUF_W));

endmodule

bind ir_frame_rx irrx_checker #(.BUF_W(BUF_W)) u_irrx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rx_busy  (rx_busy),
    .buf_full (buf_full),
    .hdr_hit  (hdr_hit),
    .d0_hit   (d0_hit),
    .d1_hit   (d1_hit),
    .spc_hit  (spc_hit),
    .err_flag (err_flag),
    .bit_cnt  (bit_cnt)
);

// File: tb/ir_frame_rx_bench.sv
`timescale 1ns/1ps
// Directed bench for ir_frame_rx: one task per scenario, each checks itself.
module ir_frame_rx_bench;

    localparam int CW    = 16;
    localparam int BUF_W = 48;
    localparam int BCW   = $clog2(BUF_W + 1);
    localparam int MAXW  = 60;   // largest window maximum (header)

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             cnt_tick = 1'b1;
    logic             sig = 1'b0;
    logic [1:0]       mode = 2'b10;
    logic             hdr_en = 1'b0;
    logic [CW-1:0]    hdr_min = 16'd40, hdr_max = 16'd60;
    logic [CW-1:0]    d0_min = 16'd8,   d0_max = 16'd12;
    logic [CW-1:0]    d1_min = 16'd18,  d1_max = 16'd24;
    logic             rx_busy, buf_full, hdr_hit, d0_hit, d1_hit, spc_hit, err_flag;
    logic [BCW-1:0]   bit_cnt;
    logic [BUF_W-1:0] rx_buf;

    int checks = 0;
    int fails  = 0;
    logic [BUF_W-1:0] exp_buf;

    always #2.5 clk = ~clk;

    ir_frame_rx #(.CW(CW), .BUF_W(BUF_W)) u_ir_frame_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_tick(cnt_tick),
        .sig_in(sig), .meas_mode(mode), .hdr_en(hdr_en),
        .hdr_min(hdr_min), .hdr_max(hdr_max), .d0_min(d0_min), .d0_max(d0_max),
        .d1_min(d1_min), .d1_max(d1_max),
        .rx_busy(rx_busy), .buf_full(buf_full), .hdr_hit(hdr_hit), .d0_hit(d0_hit),
        .d1_hit(d1_hit), .spc_hit(spc_hit), .err_flag(err_flag),
        .bit_cnt(bit_cnt), .rx_buf(rx_buf)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flags packed as {hdr, d0, d1, spc}.
    function automatic logic [63:0] flg();
        return {60'd0, hdr_hit, d0_hit, d1_hit, spc_hit};
    endfunction

    // Set the input level at a falling edge, hold for len rising edges, settle.
    task automatic drive(input logic lvl, input int len);
        @(negedge clk);
        sig = lvl;
        repeat (len) @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && rx_busy; i++) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(posedge clk); #1;
        chk("R5 reset busy", rx_busy, 0);
        chk("R5 reset flags", flg(), 0);
        chk("R5 reset count/full/err", {bit_cnt, buf_full, err_flag}, 0);
        chk("R5 reset buffer", rx_buf, 0);
    endtask

    // Width mode frame with header gating, classes, special, error.
    task automatic t_width_frame();
        mode = 2'b10; hdr_en = 1'b1;
        drive(1'b1, 21);
        chk("R3 rise starts frame", rx_busy, 1);
        drive(1'b0, 51);
        chk("R10 data gated before header flags", flg(), 0);
        chk("R10 data gated before header count", bit_cnt, 0);
        drive(1'b1, 11);
        chk("R6 header match", flg(), 4'b1000);
        drive(1'b0, 21);
        chk("R8 data0 flag", flg(), 4'b0100);
        chk("R8 data0 count", bit_cnt, 1);
        drive(1'b1, 46);
        chk("R8 data1 flag", flg(), 4'b0010);
        chk("R8 data1 buffer", rx_buf, 48'b01);
        drive(1'b0, 31);
        chk("R7 second header is special", flg(), 4'b0001);
        drive(1'b1, 11);
        chk("R9 miss sets error", err_flag, 1);
        chk("R9 miss clears flags", flg(), 0);
        drive(1'b0, 2);
        chk("R9 error sticky", err_flag, 1);
        chk("R8 buffer after three bits", rx_buf, 48'b010);
        chk("R8 count after three bits", bit_cnt, 3);
        repeat (MAXW) @(posedge clk);
        #1;
        chk("R4 busy held until limit passed", rx_busy, 1);
        @(posedge clk); #1;
        chk("R4 busy clears after timeout", rx_busy, 0);
        chk("R4 flags persist after frame", flg(), 4'b0100);
    endtask

    // Period mode: rise-to-rise measurement, frame start clears state.
    task automatic t_period();
        mode = 2'b00; hdr_en = 1'b0;
        drive(1'b1, 5);
        chk("R11 start clears error", err_flag, 0);
        chk("R11 start clears buffer/count", {rx_buf, bit_cnt}, 0);
        chk("R11 start clears flags", flg(), 0);
        drive(1'b0, 6);
        chk("R1 falling edge ignored", flg(), 0);
        drive(1'b1, 3);
        chk("R1 period data0", flg(), 4'b0100);
        drive(1'b0, 20);
        drive(1'b1, 1);
        chk("R1 period data1", flg(), 4'b0010);
        chk("R1 period buffer", rx_buf, 48'b01);
        wait_idle();
    endtask

    // High-width mode; counter freeze on missing ticks.
    task automatic t_high();
        mode = 2'b01;
        drive(1'b0, 3);
        chk("R2 idle falling edge no start", rx_busy, 0);
        drive(1'b1, 11);
        chk("R2 rise starts", rx_busy, 1);
        drive(1'b0, 5);
        chk("R2 high width data0", {flg(), 8'(bit_cnt)}, {4'b0100, 8'd1});
        drive(1'b1, 21);
        chk("R2 rise does not measure", {flg(), 8'(bit_cnt)}, {4'b0100, 8'd1});
        drive(1'b0, 1);
        chk("R2 high width data1", {flg(), 8'(bit_cnt)}, {4'b0010, 8'd2});
        @(negedge clk); cnt_tick = 1'b0;
        repeat (200) @(posedge clk);
        #1;
        chk("R4 no ticks keeps frame open", rx_busy, 1);
        @(negedge clk); cnt_tick = 1'b1;
        wait_idle();
        chk("R4 ticks resume then timeout", rx_busy, 0);
    endtask

    // Width mode starting on a falling edge, then disable.
    task automatic t_fall_start_disable();
        @(negedge clk); enable = 1'b0;
        drive(1'b1, 2);
        @(negedge clk); enable = 1'b1; mode = 2'b10;
        drive(1'b0, 11);
        chk("R3 fall starts frame", rx_busy, 1);
        drive(1'b1, 1);
        chk("R3 edge measures", flg(), 4'b0100);
        @(negedge clk); enable = 1'b0;
        @(posedge clk); #1;
        chk("R5 disable clears busy/flags", {rx_busy, flg()}, 0);
        chk("R5 disable clears count/buffer", {rx_buf, bit_cnt}, 0);
        @(negedge clk); enable = 1'b1;
    endtask

    // Fill the buffer past 48 bits.
    task automatic t_fill();
        logic b;
        hdr_en = 1'b0;
        exp_buf = '0;
        drive(~sig, 21);
        for (int i = 0; i < 49; i++) begin
            b = (i % 3 == 0);
            drive(~sig, ((i + 1) % 3 == 0) ? 21 : 11);
            exp_buf = {exp_buf[BUF_W-2:0], b};
            if (i == 46) chk("R12 count 47 not full", {buf_full, 8'(bit_cnt)}, {1'b0, 8'd47});
            if (i == 47) begin
                chk("R12 full at 48", {buf_full, 8'(bit_cnt)}, {1'b1, 8'd48});
                chk("R12 buffer at 48", rx_buf, exp_buf);
            end
            if (i == 48) begin
                chk("R12 wrap to 1 clears full", {buf_full, 8'(bit_cnt)}, {1'b0, 8'd1});
                chk("R8 buffer keeps shifting", rx_buf, exp_buf);
            end
        end
        wait_idle();
    endtask

    // Overlapping windows: data-0 outranks data-1.
    task automatic t_overlap();
        d1_min = 16'd8; d1_max = 16'd12;
        drive(~sig, 11);
        drive(~sig, 1);
        chk("R8 overlap data0 wins", flg(), 4'b0100);
        chk("R8 overlap shifts 0", rx_buf, 0);
        wait_idle();
        d1_min = 16'd18; d1_max = 16'd24;
    endtask

    initial begin
        t_reset();
        t_width_frame();
        t_period();
        t_high();
        t_fall_start_disable();
        t_fill();
        t_overlap();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule